// File: doc/BRIEF.md
# Dual-Timebase Prescaled Interrupt Timer

This block keeps two independent timebases. Each has a 32-bit up counter that divides the timer clock by a programmable prescale value and drives a 32-bit free-running counter. Four compare channels each watch one of the two free-running counters, chosen per channel. A match sets a sticky flag that can drive a level interrupt, a one-clock DMA request, or both. When a free-running counter wraps, it raises its own overflow flag. A capture strobe copies all four counters in a single clock.

Software reaches everything through a flat word-addressed register port. Writes take effect at the next clock edge. Reads are combinational. Each block has a run bit. While a block is stopped its counters hold and can be preloaded. A read of a free-running counter latches the matching up counter, so the next read of that up counter's address returns a value coherent with the first read.

Top module: `dual_tbase_timer`

## Requirements
- R1: After reset, every counter, prescale value, compare value, source select, enable bit, flag and run bit is zero. evt_irq, evt_dma and ovf_irq are low, and the run-control register (address 0) and the flag register (address 12) read 0.
- R2: Block b runs while bit b of address 0 is 1. With a nonzero prescale value N (address 3 for block 0, address 6 for block 1), its free-running counter advances once every N+1 clocks, and the up counter returns to 0 on the clock of each advance.
- R3: With a prescale value of 0, the up counter steps through the full 32-bit range. After wrapping from 0xFFFFFFFF it reads 0 on two consecutive clocks, and the free-running counter advances on the second of them.
- R4: When a free-running counter wraps from 0xFFFFFFFF to 0, bit 4+b of the flag register (address 12) sets. ovf_irq is high while any overflow flag is set together with its enable bit 8+b of the enable register (address 11).
- R5: Compare channel c has its value at address 16+c and its source in bit 0 at address 20+c (0 selects block 0, 1 selects block 1). It sets bit c of the flag register on the edge at which its selected free-running counter steps to the value. The other block's counter never sets it.
- R6: When DMA enable bit 4+c of address 11 is set, evt_dma[c] is high for exactly one clock, starting at the edge that sets flag c.
- R7: evt_irq[c] is high while flag c and interrupt enable bit c of address 11 are both set. Writing 1 to a flag-register bit clears that flag, and writing 0 leaves it unchanged.
- R8: A clock with cap_strobe high copies the four counters, all taken from that same clock, into capture registers. For block b, the free-running value goes to address 7+2b and the up counter value to address 8+2b.
- R9: A write to the free-running counter (address 1+3b) or the up counter (address 2+3b) of block b loads it only while that block is stopped. While the block runs, such writes are ignored. A stopped block holds both of its counters.
- R10: A read of address 1+3b with reg_rd high latches block b's up counter. Later reads of address 2+3b return that latched value, not the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (latches the up counter on a free-running read) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cap_strobe | input | 1 | Hardware capture event |
| evt_irq | output | 4 | Per-channel compare interrupt levels |
| evt_dma | output | 4 | Per-channel one-clock DMA requests |
| ovf_irq | output | 1 | Combined enabled overflow interrupt |

## Verification
- **Counters:** a counter started by the write at edge E0 and stopped by the write at edge En has advanced exactly n times. The bench therefore sets every run window by edge count and reads results only after the block is stopped.
- **Register reads:** read data is due in the same cycle as the read strobe. The monitor samples it a quarter period after the falling edge on which the driver raised the strobe.
- **Flags and outputs:** flags, evt_irq and ovf_irq change at the edge where the counter reaches its value. evt_dma is due for the single cycle after that edge, so a falling-edge pulse counter must see exactly one high sample.
- **Capture:** the capture registers hold the counts from the clock before the edge on which cap_strobe is sampled.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  // Register word addresses
  localparam int A_CTRL     = 0;   // run bits
  localparam int A_BLK      = 1;   // first counter block window
  localparam int BLK_STRIDE = 3;
  localparam int OFS_FRC    = 0;
  localparam int OFS_UC     = 1;   // reads the latched snapshot
  localparam int OFS_PRE    = 2;
  localparam int A_CAP      = 7;   // capture window
  localparam int CAP_STRIDE = 2;
  localparam int A_INTEN    = 11;
  localparam int A_FLAGS    = 12;
  localparam int A_CMP      = 16;
  localparam int A_SEL      = 20;
endpackage

// File: rtl/tbt_cnt_block.sv
module tbt_cnt_block #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] pre,
  input  logic          ld_uc,
  input  logic          ld_frc,
  input  logic [CW-1:0] ld_val,
  input  logic          cap,
  input  logic          snap,
  output logic [CW-1:0] uc,
  output logic [CW-1:0] frc,
  output logic          tick,
  output logic          ovf,
  output logic [CW-1:0] cap_uc,
  output logic [CW-1:0] cap_frc,
  output logic [CW-1:0] shadow_uc
);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [CW-1:0] uc_n, frc_n;
  logic          hold, hold_n;

  always_comb begin
    uc_n   = uc;
    frc_n  = frc;
    hold_n = hold;
    tick   = 1'b0;
    if (!run) begin
      if (ld_uc) begin
        uc_n   = ld_val;
        hold_n = 1'b0;
      end
      if (ld_frc) frc_n = ld_val;
    end else if (pre == '0) begin
      // full-range divide: one extra cycle parked at zero after wrap
      if (hold) begin
        hold_n = 1'b0;
        tick   = 1'b1;
      end else begin
        uc_n = uc + CW'(1);
        if (uc == ALL1) hold_n = 1'b1;
      end
    end else if (uc == pre) begin
      uc_n = '0;
      tick = 1'b1;
    end else begin
      uc_n = uc + CW'(1);
    end
    if (tick) frc_n = frc + CW'(1);
  end

  assign ovf = tick && (frc == ALL1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc        <= '0;
      frc       <= '0;
      hold      <= 1'b0;
      cap_uc    <= '0;
      cap_frc   <= '0;
      shadow_uc <= '0;
    end else begin
      uc   <= uc_n;
      frc  <= frc_n;
      hold <= hold_n;
      if (cap) begin
        cap_uc  <= uc;
        cap_frc <= frc;
      end
      if (snap) shadow_uc <= uc;
    end
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre != '0 && uc == pre) |=> (uc == '0 && frc == $past(frc) + CW'(1)));

  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre == '0 && uc == ALL1) |=> (uc == '0 && $stable(frc)));

  p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (frc == '0));

  p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_uc && !ld_frc) |=> ($stable(uc) && $stable(frc)));

  p_run_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && ld_frc) |=> $stable(frc));
endmodule

// File: rtl/tbt_cmp_chan.sv
module tbt_cmp_chan #(
  parameter int CW   = 32,
  parameter int NBLK = 2,
  parameter int SW   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NBLK-1:0][CW-1:0]   frc,
  input  logic [NBLK-1:0]           tick,
  input  logic [CW-1:0]             val,
  input  logic [SW-1:0]             sel,
  input  logic                      clr,
  input  logic                      irq_en,
  input  logic                      dma_en,
  output logic                      flag,
  output logic                      irq,
  output logic                      dma
);
  logic match, flag_n, dma_n;

  // match on the edge where the chosen counter steps onto the value
  assign match  = tick[sel] && ((frc[sel] + CW'(1)) == val);
  assign flag_n = match | (flag & ~clr);
  assign dma_n  = match & dma_en;
  assign irq    = flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      dma  <= 1'b0;
    end else begin
      flag <= flag_n;
      dma  <= dma_n;
    end
  end

  p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  p_dma_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma |=> !dma);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/dual_tbase_timer.sv
module dual_tbase_timer
  import tbt_pkg::*;
#(
  parameter int CW   = 32,
  parameter int NBLK = 2,
  parameter int NCH  = 4,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          cap_strobe,
  output logic [NCH-1:0] evt_irq,
  output logic [NCH-1:0] evt_dma,
  output logic          ovf_irq
);
  localparam int SW = (NBLK > 1) ? $clog2(NBLK) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  // configuration and flag state
  logic [NBLK-1:0]          run_q, run_n;
  logic [NBLK-1:0][CW-1:0]  pre_q, pre_n;
  logic [NCH-1:0][CW-1:0]   val_q, val_n;
  logic [NCH-1:0][SW-1:0]   sel_q, sel_n;
  logic [NCH-1:0]           ien_q, ien_n, den_q, den_n;
  logic [NBLK-1:0]          oen_q, oen_n, oflag_q, oflag_n;

  logic [NBLK-1:0][CW-1:0]  uc, frc, cap_uc, cap_frc, shadow_uc;
  logic [NBLK-1:0]          tick, ovf, ld_uc, ld_frc, snap;
  logic [NCH-1:0]           cflag, clr;
  logic                     flags_wr;

  assign flags_wr = reg_wr && (reg_addr == AW'(A_FLAGS));

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam int BA = A_BLK + b * BLK_STRIDE;
    assign ld_uc[b]  = reg_wr && (reg_addr == AW'(BA + OFS_UC));
    assign ld_frc[b] = reg_wr && (reg_addr == AW'(BA + OFS_FRC));
    assign snap[b]   = reg_rd && (reg_addr == AW'(BA + OFS_FRC));

    tbt_cnt_block #(.CW(CW)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_i),
      .run       (run_q[b]),
      .pre       (pre_q[b]),
      .ld_uc     (ld_uc[b]),
      .ld_frc    (ld_frc[b]),
      .ld_val    (reg_wdata),
      .cap       (cap_strobe),
      .snap      (snap[b]),
      .uc        (uc[b]),
      .frc       (frc[b]),
      .tick      (tick[b]),
      .ovf       (ovf[b]),
      .cap_uc    (cap_uc[b]),
      .cap_frc   (cap_frc[b]),
      .shadow_uc (shadow_uc[b])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign clr[c] = flags_wr && reg_wdata[c];

    tbt_cmp_chan #(.CW(CW), .NBLK(NBLK), .SW(SW)) i_chan (
      .clk    (clk),
      .rst_n  (rst_i),
      .frc    (frc),
      .tick   (tick),
      .val    (val_q[c]),
      .sel    (sel_q[c]),
      .clr    (clr[c]),
      .irq_en (ien_q[c]),
      .dma_en (den_q[c]),
      .flag   (cflag[c]),
      .irq    (evt_irq[c]),
      .dma    (evt_dma[c])
    );
  end

  // next-state for configuration registers
  always_comb begin
    run_n = run_q;
    pre_n = pre_q;
    val_n = val_q;
    sel_n = sel_q;
    ien_n = ien_q;
    den_n = den_q;
    oen_n = oen_q;
    if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL)) run_n = reg_wdata[NBLK-1:0];
      if (reg_addr == AW'(A_INTEN)) begin
        ien_n = reg_wdata[NCH-1:0];
        den_n = reg_wdata[2*NCH-1:NCH];
        oen_n = reg_wdata[2*NCH+NBLK-1:2*NCH];
      end
      for (int b = 0; b < NBLK; b++)
        if (reg_addr == AW'(A_BLK + b*BLK_STRIDE + OFS_PRE)) pre_n[b] = reg_wdata;
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == AW'(A_CMP + c)) val_n[c] = reg_wdata;
        if (reg_addr == AW'(A_SEL + c)) sel_n[c] = reg_wdata[SW-1:0];
      end
    end
    for (int b = 0; b < NBLK; b++)
      oflag_n[b] = ovf[b] | (oflag_q[b] & ~(flags_wr & reg_wdata[NCH+b]));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q   <= '0;
      pre_q   <= '0;
      val_q   <= '0;
      sel_q   <= '0;
      ien_q   <= '0;
      den_q   <= '0;
      oen_q   <= '0;
      oflag_q <= '0;
    end else begin
      run_q   <= run_n;
      pre_q   <= pre_n;
      val_q   <= val_n;
      sel_q   <= sel_n;
      ien_q   <= ien_n;
      den_q   <= den_n;
      oen_q   <= oen_n;
      oflag_q <= oflag_n;
    end
  end

  assign ovf_irq = |(oflag_q & oen_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) reg_rdata[NBLK-1:0] = run_q;
    if (reg_addr == AW'(A_INTEN)) begin
      reg_rdata[NCH-1:0]             = ien_q;
      reg_rdata[2*NCH-1:NCH]         = den_q;
      reg_rdata[2*NCH+NBLK-1:2*NCH]  = oen_q;
    end
    if (reg_addr == AW'(A_FLAGS)) begin
      reg_rdata[NCH-1:0]        = cflag;
      reg_rdata[NCH+NBLK-1:NCH] = oflag_q;
    end
    for (int b = 0; b < NBLK; b++) begin
      if (reg_addr == AW'(A_BLK + b*BLK_STRIDE + OFS_FRC)) reg_rdata = frc[b];
      if (reg_addr == AW'(A_BLK + b*BLK_STRIDE + OFS_UC))  reg_rdata = shadow_uc[b];
      if (reg_addr == AW'(A_BLK + b*BLK_STRIDE + OFS_PRE)) reg_rdata = pre_q[b];
      if (reg_addr == AW'(A_CAP + b*CAP_STRIDE))           reg_rdata = cap_frc[b];
      if (reg_addr == AW'(A_CAP + b*CAP_STRIDE + 1))       reg_rdata = cap_uc[b];
    end
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(A_CMP + c)) reg_rdata = val_q[c];
      if (reg_addr == AW'(A_SEL + c)) reg_rdata[SW-1:0] = sel_q[c];
    end
  end

  p_ovf_irq_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (|(ovf & oen_q)) |=> ovf_irq);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (evt_irq & ~cflag) == '0);

  p_dma_onehot_r6: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(evt_dma & ~den_q) && ((evt_dma & ~den_q) == '0));
endmodule

// File: tb/test_dual_tbase_timer.sv
module test_dual_tbase_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SMP = CLK_PERIOD / 4;

  logic        clk, rst_n, reg_wr, reg_rd, cap_strobe;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  evt_irq, evt_dma;
  logic        ovf_irq;

  dual_tbase_timer i_dual_tbase_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_strobe(cap_strobe), .evt_irq(evt_irq), .evt_dma(evt_dma),
    .ovf_irq(ovf_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  int total = 0;
  int fails = 0;
  bit done  = 0;
  int dma_cnt [4];

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data while reg_rd is high
  initial begin
    forever begin
      @(negedge clk);
      #(SMP);
      if (reg_rd) begin
        total++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL scoreboard empty actual %h expected none", reg_rdata);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (reg_rdata !== it.exp || reg_addr !== it.addr) begin
            fails++;
            $display("FAIL %s addr %0d actual %h expected %h",
                     it.tag, it.addr, reg_rdata, it.exp);
          end
        end
      end
    end
  end

  always @(negedge clk)
    for (int c = 0; c < 4; c++) if (rst_n && evt_dma[c]) dma_cnt[c]++;

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    report();
  end

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int addr, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'(addr);
    it.addr = 5'(addr); it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // after a start write, lets the next stop write land on the n-th edge
  task automatic run_for(int n);
    repeat (n - 2) @(negedge clk);
  endtask

  task automatic settle();
    #(SMP);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) dma_cnt[c] = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; cap_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    settle();
    chk("R1 evt_irq", 32'(evt_irq), 0);
    chk("R1 evt_dma", 32'(evt_dma), 0);
    chk("R1 ovf_irq", 32'(ovf_irq), 0);
    rd(0, 0, "R1 ctrl");
    rd(1, 0, "R1 frc0");
    rd(12, 0, "R1 flags");

    for (int c = 0; c < 4; c++) wr(16 + c, 32'h5555_5555);

    // R2 divide by 3
    wr(3, 2);
    wr(0, 1);
    run_for(10);
    wr(0, 0);
    rd(1, 3, "R2 frc0 after 10 clocks");
    rd(2, 1, "R2 uc0 after 10 clocks");

    // R3 prescale zero: two clocks parked at zero
    wr(3, 0);
    wr(2, 32'hFFFF_FFFD);
    wr(1, 5);
    wr(0, 1);
    run_for(3);
    wr(0, 0);
    rd(1, 5, "R3 frc0 before hold tick");
    rd(2, 0, "R3 uc0 wrapped");
    wr(0, 1);
    run_for(2);
    wr(0, 0);
    rd(1, 6, "R3 frc0 after hold tick");
    rd(2, 1, "R3 uc0 resumes");

    // R4 overflow
    wr(3, 1);
    wr(2, 0);
    wr(1, 32'hFFFF_FFFE);
    wr(11, 32'h100);
    wr(0, 1);
    run_for(3);
    wr(0, 0);
    settle();
    chk("R4 ovf_irq before wrap", 32'(ovf_irq), 0);
    rd(12, 0, "R4 flags before wrap");
    wr(0, 1);
    run_for(2);
    wr(0, 0);
    settle();
    chk("R4 ovf_irq after wrap", 32'(ovf_irq), 1);
    rd(12, 32'h10, "R4 overflow flag");
    rd(1, 0, "R4 frc0 wrapped");
    wr(12, 32'h10);
    settle();
    chk("R4 ovf_irq cleared", 32'(ovf_irq), 0);

    // R5 R6 routing and DMA pulse
    wr(11, 32'h53);
    wr(16, 3);  wr(20, 0);
    wr(17, 101); wr(21, 0);
    wr(18, 3);  wr(22, 1);
    wr(6, 1);
    wr(0, 2);
    run_for(8);
    wr(0, 0);
    settle();
    chk("R5 evt_irq ch0 untouched by block1", 32'(evt_irq), 0);
    chk("R6 dma pulses ch2", dma_cnt[2], 1);
    chk("R6 dma pulses ch0", dma_cnt[0], 0);
    rd(12, 32'h4, "R5 flags after block1 reaches 3");
    rd(4, 4, "R2 frc1 divide by 2");
    wr(12, 32'h4);
    rd(12, 0, "R7 flag cleared by write 1");

    // R8 R9 R10 capture, ignored write, snapshot
    wr(3, 3); wr(2, 0); wr(1, 100);
    wr(5, 0); wr(4, 200);
    wr(0, 3);
    repeat (5) @(negedge clk);
    @(negedge clk); cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
    wr(1, 7);
    wr(0, 0);
    settle();
    chk("R7 evt_irq ch1", 32'(evt_irq), 32'h2);
    rd(2, 1, "R10 uc0 snapshot is stale until frc0 read");
    rd(1, 102, "R9 frc0 ignores write while running");
    rd(2, 3, "R10 uc0 snapshot");
    rd(4, 205, "R9 frc1");
    rd(5, 1, "R10 uc1 snapshot");
    rd(7, 101, "R8 cap frc0");
    rd(8, 2, "R8 cap uc0");
    rd(9, 203, "R8 cap frc1");
    rd(10, 0, "R8 cap uc1");
    rd(12, 32'h2, "R5 flags ch1 from block0");
    wr(12, 32'h1);
    settle();
    chk("R7 write 0 leaves flag", 32'(evt_irq), 32'h2);
    wr(12, 32'h2);
    settle();
    chk("R7 evt_irq cleared", 32'(evt_irq), 0);
    chk("R6 dma total ch2", dma_cnt[2], 1);
    chk("R6 dma total ch0", dma_cnt[0], 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule